// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Faults

This block sits between decode and the architectural state of a pipelined core. It lets instructions finish execution in any order but only lets their results reach the register file or memory in program order. At decode an instruction claims the next free slot of a circular queue and receives that slot's tag. Execution units later post a result, an address and an exception flag to the slot named by the tag. Each cycle the queue looks at its oldest slot. If that slot has finished cleanly, its result leaves on the register write port or the memory write port, according to the kind recorded at decode.

When the oldest finished slot carries an exception, nothing is committed from it. The queue instead drops every outstanding slot, returns both pointers to slot zero and, in the following cycle, presents the faulting instruction's PC on a one-cycle redirect output. All older instructions have already committed and no younger one has, so the state seen by the handler is precise.

Top module: `rob_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty: alloc_ready is 1, alloc_tag is 0, and rf_we, mem_we and redirect_valid are 0.
- R2: alloc_tag names the slot that the next accepted allocation takes. Successive accepted allocations receive tags 0, 1, 2 and onward, wrapping from DEPTH-1 to 0.
- R3: With DEPTH slots outstanding, alloc_ready is 0 and a held alloc_req allocates nothing. alloc_ready returns to 1 once a slot has retired.
- R4: A completion on any port marks the slot named by its tag as finished and records its data, address and exception bit. When two ports name the same slot in one cycle, the higher-numbered port's values are kept. A completion naming a slot that is not occupied at that clock edge is ignored. This includes a slot being allocated in the same cycle.
- R5: Only the oldest slot may retire, at most one slot per cycle. It retires only once it has finished. A finished younger slot waits behind an unfinished older one.
- R6: The kind code is set at allocation. Code 01 is a register write: rf_we with rf_waddr equal to the destination and rf_wdata equal to the completion data. Code 10 is a store: mem_we with mem_addr and mem_wdata taken from the completion. Codes 00 and 11 retire with no write. rf_we and mem_we are never both high.
- R7: When the oldest slot has finished with its exception bit set, it does not commit. At that edge every slot is freed and both pointers return to 0. In the next cycle redirect_valid is 1 for exactly one cycle, with redirect_pc equal to that slot's PC, and alloc_tag is 0.
- R8: A slot that finished with an exception while older slots were still outstanding has no effect until those older slots have committed.
- R9: In the cycle in which the oldest slot is a finished exception, alloc_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_kind | input | 2 | Result kind: 00 none, 01 register, 10 store, 11 none |
| alloc_dest | input | REG_W | Destination register number |
| alloc_pc | input | PC_W | PC of the allocating instruction |
| alloc_ready | output | 1 | A request in this cycle is accepted |
| alloc_tag | output | TAG_W | Tag given to the request accepted in this cycle |
| cpl_valid | input | NUM_CPL | Per-port completion strobe |
| cpl_tag | input | NUM_CPL*TAG_W | Per-port slot tag |
| cpl_data | input | NUM_CPL*DATA_W | Per-port result or store data |
| cpl_addr | input | NUM_CPL*ADDR_W | Per-port store address |
| cpl_excp | input | NUM_CPL | Per-port exception flag |
| rf_we | output | 1 | Register write at retirement |
| rf_waddr | output | REG_W | Register number written |
| rf_wdata | output | DATA_W | Register value written |
| mem_we | output | 1 | Store at retirement |
| mem_addr | output | ADDR_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| redirect_valid | output | 1 | One-cycle fetch redirect after a fault |
| redirect_pc | output | PC_W | PC of the faulting instruction |

## Verification
The hardest situation to reach is a finished exception that sits behind an unfinished older slot, with further younger work queued behind it. The bench builds this by allocating three slots and completing the middle one with its exception flag, then the youngest, and the oldest last. The oldest must then commit and the fault must follow one cycle later, with the youngest result discarded. A completion aimed at a slot in the very cycle the slot is being allocated is another state that is hard to reach. The bench issues exactly that and then watches the slot stay unretired until a real completion arrives. A long stretch of random allocation, completion and rare exceptions, checked against a queue-based model on every clock, covers the wrap of the pointers.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam logic [1:0] KIND_NONE  = 2'b00;
  localparam logic [1:0] KIND_REG   = 2'b01;
  localparam logic [1:0] KIND_STORE = 2'b10;

  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_COMMIT = 2'd1,
    ACT_FAULT  = 2'd2
  } ret_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 16,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [TAG_W-1:0] head_q,
  output logic [TAG_W-1:0] tail_q,
  output logic [CNT_W-1:0] count_q,
  output logic             full,
  output logic             empty
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [TAG_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] count_n;

  always_comb begin
    head_n  = head_q;
    tail_n  = tail_q;
    count_n = count_q;
    if (flush) begin
      head_n  = '0;
      tail_n  = '0;
      count_n = '0;
    end else begin
      if (retire_fire) head_n = (head_q == LAST) ? '0 : head_q + 1'b1;
      if (alloc_fire)  tail_n = (tail_q == LAST) ? '0 : tail_q + 1'b1;
      case ({alloc_fire, retire_fire})
        2'b10:   count_n = count_q + 1'b1;
        2'b01:   count_n = count_q - 1'b1;
        default: count_n = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
    end
  end

  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = $clog2(DEPTH),
  parameter int NUM_CPL = 2,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_fire,
  input  logic [TAG_W-1:0]          alloc_idx,
  input  logic [1:0]                alloc_kind,
  input  logic [REG_W-1:0]          alloc_dest,
  input  logic [PC_W-1:0]           alloc_pc,
  input  logic [NUM_CPL-1:0]        cpl_valid,
  input  logic [NUM_CPL*TAG_W-1:0]  cpl_tag,
  input  logic [NUM_CPL*DATA_W-1:0] cpl_data,
  input  logic [NUM_CPL*ADDR_W-1:0] cpl_addr,
  input  logic [NUM_CPL-1:0]        cpl_excp,
  input  logic                      retire_fire,
  input  logic                      flush,
  input  logic [TAG_W-1:0]          head_idx,
  output logic                      hd_valid,
  output logic                      hd_done,
  output logic                      hd_excp,
  output logic [1:0]                hd_kind,
  output logic [REG_W-1:0]          hd_dest,
  output logic [DATA_W-1:0]         hd_data,
  output logic [ADDR_W-1:0]         hd_addr,
  output logic [PC_W-1:0]           hd_pc
);
  logic [DEPTH-1:0] valid_vec, done_vec, excp_vec;
  logic [1:0]        kind_arr [DEPTH];
  logic [REG_W-1:0]  dest_arr [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];
  logic [ADDR_W-1:0] addr_arr [DEPTH];
  logic [PC_W-1:0]   pc_arr   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [TAG_W-1:0] IDX = TAG_W'(i);

    logic              v_q, v_n, d_q, d_n, e_q, e_n;
    logic [1:0]        k_q, k_n;
    logic [REG_W-1:0]  r_q, r_n;
    logic [DATA_W-1:0] x_q, x_n;
    logic [ADDR_W-1:0] a_q, a_n;
    logic [PC_W-1:0]   p_q, p_n;

    always_comb begin
      v_n = v_q;  d_n = d_q;  e_n = e_q;
      k_n = k_q;  r_n = r_q;  x_n = x_q;  a_n = a_q;  p_n = p_q;
      // later ports override earlier ones on a shared tag
      for (int p = 0; p < NUM_CPL; p++) begin
        if (cpl_valid[p] && v_q && (cpl_tag[p*TAG_W +: TAG_W] == IDX)) begin
          d_n = 1'b1;
          e_n = cpl_excp[p];
          x_n = cpl_data[p*DATA_W +: DATA_W];
          a_n = cpl_addr[p*ADDR_W +: ADDR_W];
        end
      end
      if (retire_fire && (head_idx == IDX)) begin
        v_n = 1'b0;
        d_n = 1'b0;
      end
      if (alloc_fire && (alloc_idx == IDX)) begin
        v_n = 1'b1;
        d_n = 1'b0;
        e_n = 1'b0;
        k_n = alloc_kind;
        r_n = alloc_dest;
        p_n = alloc_pc;
      end
      if (flush) begin
        v_n = 1'b0;
        d_n = 1'b0;
        e_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        v_q <= v_n;
        d_q <= d_n;
        e_q <= e_n;
      end
    end

    always_ff @(posedge clk) begin
      k_q <= k_n;
      r_q <= r_n;
      x_q <= x_n;
      a_q <= a_n;
      p_q <= p_n;
    end

    assign valid_vec[i] = v_q;
    assign done_vec[i]  = d_q;
    assign excp_vec[i]  = e_q;
    assign kind_arr[i]  = k_q;
    assign dest_arr[i]  = r_q;
    assign data_arr[i]  = x_q;
    assign addr_arr[i]  = a_q;
    assign pc_arr[i]    = p_q;
  end

  assign hd_valid = valid_vec[head_idx];
  assign hd_done  = done_vec[head_idx];
  assign hd_excp  = excp_vec[head_idx];
  assign hd_kind  = kind_arr[head_idx];
  assign hd_dest  = dest_arr[head_idx];
  assign hd_data  = data_arr[head_idx];
  assign hd_addr  = addr_arr[head_idx];
  assign hd_pc    = pc_arr[head_idx];
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              not_empty,
  input  logic              hd_valid,
  input  logic              hd_done,
  input  logic              hd_excp,
  input  logic [1:0]        hd_kind,
  input  logic [REG_W-1:0]  hd_dest,
  input  logic [DATA_W-1:0] hd_data,
  input  logic [ADDR_W-1:0] hd_addr,
  input  logic [PC_W-1:0]   hd_pc,
  output logic              retire_fire,
  output logic              fault,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              redirect_valid,
  output logic [PC_W-1:0]   redirect_pc
);
  ret_act_e  act;
  logic      redir_n;
  logic [PC_W-1:0] rpc_n;

  always_comb begin
    act = ACT_IDLE;
    if (not_empty && hd_valid && hd_done) act = hd_excp ? ACT_FAULT : ACT_COMMIT;
  end

  assign retire_fire = (act == ACT_COMMIT);
  assign fault       = (act == ACT_FAULT);

  assign rf_we     = retire_fire && (hd_kind == KIND_REG);
  assign rf_waddr  = hd_dest;
  assign rf_wdata  = hd_data;
  assign mem_we    = retire_fire && (hd_kind == KIND_STORE);
  assign mem_addr  = hd_addr;
  assign mem_wdata = hd_data;

  always_comb begin
    redir_n = fault;
    rpc_n   = fault ? hd_pc : redirect_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect_valid <= 1'b0;
    else        redirect_valid <= redir_n;
  end

  always_ff @(posedge clk) begin
    redirect_pc <= rpc_n;
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH   = 16,
  parameter int NUM_CPL = 2,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 32,
  parameter int TAG_W   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_req,
  input  logic [1:0]                alloc_kind,
  input  logic [REG_W-1:0]          alloc_dest,
  input  logic [PC_W-1:0]           alloc_pc,
  output logic                      alloc_ready,
  output logic [TAG_W-1:0]          alloc_tag,
  input  logic [NUM_CPL-1:0]        cpl_valid,
  input  logic [NUM_CPL*TAG_W-1:0]  cpl_tag,
  input  logic [NUM_CPL*DATA_W-1:0] cpl_data,
  input  logic [NUM_CPL*ADDR_W-1:0] cpl_addr,
  input  logic [NUM_CPL-1:0]        cpl_excp,
  output logic                      rf_we,
  output logic [REG_W-1:0]          rf_waddr,
  output logic [DATA_W-1:0]         rf_wdata,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  output logic                      redirect_valid,
  output logic [PC_W-1:0]           redirect_pc
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             full, empty, alloc_fire, retire_fire, fault;
  logic             hd_valid, hd_done, hd_excp;
  logic [1:0]        hd_kind;
  logic [REG_W-1:0]  hd_dest;
  logic [DATA_W-1:0] hd_data;
  logic [ADDR_W-1:0] hd_addr;
  logic [PC_W-1:0]   hd_pc;

  assign alloc_ready = !full && !fault;
  assign alloc_fire  = alloc_req && alloc_ready;
  assign alloc_tag   = tail_q;

  rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .retire_fire(retire_fire),
    .flush(fault), .head_q(head_q), .tail_q(tail_q), .count_q(count_q),
    .full(full), .empty(empty)
  );

  rob_entries #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .NUM_CPL(NUM_CPL), .REG_W(REG_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_idx(tail_q),
    .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
    .cpl_addr(cpl_addr), .cpl_excp(cpl_excp), .retire_fire(retire_fire),
    .flush(fault), .head_idx(head_q), .hd_valid(hd_valid), .hd_done(hd_done),
    .hd_excp(hd_excp), .hd_kind(hd_kind), .hd_dest(hd_dest), .hd_data(hd_data),
    .hd_addr(hd_addr), .hd_pc(hd_pc)
  );

  rob_retire #(.REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .not_empty(!empty), .hd_valid(hd_valid),
    .hd_done(hd_done), .hd_excp(hd_excp), .hd_kind(hd_kind), .hd_dest(hd_dest),
    .hd_data(hd_data), .hd_addr(hd_addr), .hd_pc(hd_pc),
    .retire_fire(retire_fire), .fault(fault), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 16,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             rf_we,
  input logic             mem_we,
  input logic             redirect_valid,
  input logic [CNT_W-1:0] occ,
  input logic             fault
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  // R2
  tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ready) |=>
      (alloc_tag == (($past(alloc_tag) == LAST) ? '0 : $past(alloc_tag) + 1'b1)));

  // R3
  full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !alloc_ready);

  // R5
  empty_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (!rf_we && !mem_we));

  // R6
  one_write_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we}));

  // R7
  fault_redirects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (redirect_valid && (occ == '0) && (alloc_tag == '0)));

  // R7
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  // R9
  fault_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!alloc_ready && !rf_we && !mem_we));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .rf_we(rf_we), .mem_we(mem_we),
  .redirect_valid(redirect_valid), .occ(count_q), .fault(fault)
);

// File: tb/rob_core_bench.sv
`timescale 1ns/1ps
module rob_core_bench;
  localparam int N = 16;

  logic clk, rst_n;
  logic a_req;
  logic [1:0] a_kind;
  logic [4:0] a_dest;
  logic [31:0] a_pc;
  logic [1:0] c_v, c_ex;
  logic [7:0] c_tag;
  logic [63:0] c_data, c_addr;
  logic alloc_ready, rf_we, mem_we, redirect_valid;
  logic [3:0] alloc_tag;
  logic [4:0] rf_waddr;
  logic [31:0] rf_wdata, mem_addr, mem_wdata, redirect_pc;

  int n_chk = 0, n_fail = 0;

  // reference model
  bit m_v[N], m_d[N], m_e[N];
  logic [1:0] m_k[N];
  logic [4:0] m_r[N];
  logic [31:0] m_pc[N], m_x[N], m_a[N];
  int m_h, m_t, m_c;
  bit m_rv;
  logic [31:0] m_rpc;

  rob_core u_rob_core (
    .clk(clk), .rst_n(rst_n), .alloc_req(a_req), .alloc_kind(a_kind),
    .alloc_dest(a_dest), .alloc_pc(a_pc), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .cpl_valid(c_v), .cpl_tag(c_tag), .cpl_data(c_data),
    .cpl_addr(c_addr), .cpl_excp(c_ex), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, string what, string sc, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s [%s]: actual %0h expected %0h", req, what, sc, act, exp);
    end
  endtask

  task automatic idle();
    a_req = 0; a_kind = 0; a_dest = 0; a_pc = 0;
    c_v = 0; c_ex = 0; c_tag = 0; c_data = 0; c_addr = 0;
  endtask

  task automatic cpl(int p, int tg, logic [31:0] d, logic [31:0] ad, bit ex);
    c_v[p] = 1'b1;
    c_tag[p*4 +: 4] = 4'(tg);
    c_data[p*32 +: 32] = d;
    c_addr[p*32 +: 32] = ad;
    c_ex[p] = ex;
  endtask

  task automatic alloc(logic [1:0] k, logic [4:0] r, logic [31:0] pc);
    a_req = 1; a_kind = k; a_dest = r; a_pc = pc;
  endtask

  // one cycle: predict, compare, advance model, cross the edge
  task automatic step(string sc);
    bit hok, flt, cmt, rdy;
    int tg;
    hok = (m_c > 0) && m_v[m_h] && m_d[m_h];
    flt = hok && m_e[m_h];
    cmt = hok && !m_e[m_h];
    rdy = (m_c < N) && !flt;
    #2;
    chk(flt ? "R9" : "R3", "alloc_ready", sc, 64'(alloc_ready), 64'(rdy));
    chk("R2", "alloc_tag", sc, 64'(alloc_tag), 64'(m_t));
    chk("R5", "rf_we", sc, 64'(rf_we), 64'(cmt && m_k[m_h] == 2'b01));
    chk("R6", "mem_we", sc, 64'(mem_we), 64'(cmt && m_k[m_h] == 2'b10));
    if (cmt && m_k[m_h] == 2'b01) begin
      chk("R6", "rf_waddr", sc, 64'(rf_waddr), 64'(m_r[m_h]));
      chk("R6", "rf_wdata", sc, 64'(rf_wdata), 64'(m_x[m_h]));
    end
    if (cmt && m_k[m_h] == 2'b10) begin
      chk("R6", "mem_addr", sc, 64'(mem_addr), 64'(m_a[m_h]));
      chk("R6", "mem_wdata", sc, 64'(mem_wdata), 64'(m_x[m_h]));
    end
    chk("R7", "redirect_valid", sc, 64'(redirect_valid), 64'(m_rv));
    if (m_rv) chk("R7", "redirect_pc", sc, 64'(redirect_pc), 64'(m_rpc));
    if (flt) begin
      m_rv = 1; m_rpc = m_pc[m_h];
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_e[i] = 0; end
      m_h = 0; m_t = 0; m_c = 0;
    end else begin
      m_rv = 0;
      for (int p = 0; p < 2; p++) begin
        tg = int'(c_tag[p*4 +: 4]);
        if (c_v[p] && m_v[tg]) begin
          m_d[tg] = 1; m_e[tg] = c_ex[p];
          m_x[tg] = c_data[p*32 +: 32]; m_a[tg] = c_addr[p*32 +: 32];
        end
      end
      if (cmt) begin
        m_v[m_h] = 0; m_d[m_h] = 0; m_h = (m_h + 1) % N; m_c--;
      end
      if (a_req && rdy) begin
        m_v[m_t] = 1; m_d[m_t] = 0; m_e[m_t] = 0;
        m_k[m_t] = a_kind; m_r[m_t] = a_dest; m_pc[m_t] = a_pc;
        m_t = (m_t + 1) % N; m_c++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_e[i] = 0; end
    m_h = 0; m_t = 0; m_c = 0; m_rv = 0; m_rpc = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state while reset is held
    chk("R1", "alloc_ready", "reset", 64'(alloc_ready), 64'd1);
    chk("R1", "alloc_tag", "reset", 64'(alloc_tag), 64'd0);
    chk("R1", "rf_we", "reset", 64'(rf_we), 64'd0);
    chk("R1", "mem_we", "reset", 64'(mem_we), 64'd0);
    chk("R1", "redirect_valid", "reset", 64'(redirect_valid), 64'd0);
    rst_n = 1;
    step("R1 after reset");

    // fill all slots, every kind code
    for (int i = 0; i < N; i++) begin
      idle(); alloc(2'(i % 4), 5'(i + 1), 32'h1000 + 32'(4 * i));
      step("R2 fill");
    end
    idle(); alloc(2'b01, 5'd30, 32'hDEAD);
    step("R3 full");
    step("R3 full held");

    // out-of-order completion, youngest first
    for (int j = 0; j < 8; j++) begin
      idle();
      cpl(0, 15 - 2 * j, 32'hD000 + 32'(15 - 2 * j), 32'hA000 + 32'(15 - 2 * j), 0);
      cpl(1, 14 - 2 * j, 32'hD000 + 32'(14 - 2 * j), 32'hA000 + 32'(14 - 2 * j), 0);
      step("R5 out of order");
    end
    idle();
    for (int j = 0; j < 18; j++) step("R5 drain");

    // completion in the allocation cycle is ignored
    idle(); alloc(2'b01, 5'd7, 32'h2000); cpl(0, 0, 32'hBAD, 32'h0, 0);
    step("R4 same-cycle alloc");
    idle();
    for (int j = 0; j < 3; j++) step("R4 ignored stays");
    cpl(0, 0, 32'h600D, 32'h0, 0);
    step("R4 real completion");
    idle(); step("R4 commit");

    // two ports on one tag
    alloc(2'b10, 5'd3, 32'h2100); step("R4 dual alloc");
    idle(); cpl(0, 1, 32'h1111, 32'hA1, 0); cpl(1, 1, 32'h2222, 32'hA2, 0);
    step("R4 dual cpl");
    idle(); step("R4 dual commit");

    // exception behind an unfinished older slot
    alloc(2'b01, 5'd10, 32'h3000); step("R8 alloc A");
    alloc(2'b01, 5'd11, 32'h3004); step("R8 alloc B");
    alloc(2'b01, 5'd12, 32'h3008); step("R8 alloc C");
    idle(); cpl(0, 3, 32'hBB, 32'h0, 1); cpl(1, 4, 32'hCC, 32'h0, 0);
    step("R8 cpl B C");
    idle(); step("R8 waits");
    cpl(0, 2, 32'hAA, 32'h0, 0); step("R8 cpl A");
    idle(); step("R8 A commits");
    alloc(2'b01, 5'd1, 32'h4000); step("R9 fault cycle");
    idle(); step("R7 redirect");
    alloc(2'b01, 5'd2, 32'h4004); step("R7 restart");
    idle(); cpl(0, 0, 32'h55, 32'h0, 0); step("R7 restart cpl");
    idle(); step("R7 restart commit");

    // exception directly at the head with a completion in the same cycle
    alloc(2'b10, 5'd0, 32'h5000); step("R7 head alloc");
    idle(); cpl(0, 1, 32'h0, 32'h0, 1); step("R7 head cpl");
    alloc(2'b01, 5'd4, 32'h5004); cpl(1, 1, 32'h9, 32'h9, 0); step("R9 head fault");
    idle(); step("R7 head redirect");

    // random traffic
    for (int j = 0; j < 600; j++) begin
      idle();
      if ($urandom_range(0, 1) == 1) alloc(2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)), $urandom());
      for (int p = 0; p < 2; p++)
        if ($urandom_range(0, 2) != 0)
          cpl(p, $urandom_range(0, N - 1), $urandom(), $urandom(), $urandom_range(0, 24) == 0);
      step("R5 random");
    end
    idle();
    for (int j = 0; j < 4; j++) step("R5 settle");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule